// File: doc/BRIEF.md
# Debug Pipeline Capture and Restore

This block keeps the processor's pipeline state intact while an on-chip debug session runs. On the cycle debug mode is entered it freezes a copy of the current instruction latch together with the program addresses sitting in the fetch and decode stages. For the length of the session it also holds a global-data-bus register. The core loads that register by writing to a fixed I/O address, which is how register or memory contents reach the external debug host.

The host can read any of these four registers, and only through a serial output. A read command loads the selected register in parallel into a shift register. Each later rising edge of the debug clock then moves the next bit onto the data-out pin, least significant bit first.

The saved instruction latch has no direct write port. The host refreshes it by writing the program-data register, but only the first such write after debug entry, or the first after a GO command, is copied. When the session ends, the saved latch value is driven onto a restore bus for one cycle, marked by a valid pulse, so that the pipeline can be reloaded.

Top module: `dbg_pipe_capture`

## Requirements
- R1: After reset the debug flag, the restore valid pulse, the restore bus, the serial output and all four held registers are zero.
- R2: An entry pulse while not in debug sets the debug flag in the next cycle. In that same cycle it also loads the saved latch from the instruction-latch input.
- R3: The same entry pulse captures the fetch-stage and decode-stage addresses. Both stay unchanged until the next accepted entry, whatever the address inputs do.
- R4: The first program-data write after an accepted entry copies its data into the saved latch.
- R5: Any further program-data write leaves the saved latch unchanged until the flag is re-armed.
- R6: A GO pulse while in debug re-arms the flag, so the next program-data write is copied again.
- R7: A core write to I/O address 0xFFFC loads the global-data register. A core write to any other address leaves it unchanged.
- R8: A read pulse loads the register chosen by the select code (0 saved latch, 1 global data, 2 fetch address, 3 decode address, addresses zero-extended to 24 bits). Bit 0 appears on the serial output in the next cycle. Each later debug-clock rising edge advances one bit, LSB first, and zeros fill in behind the last bit.
- R9: An exit pulse while in debug clears the debug flag. In the next cycle it drives the saved latch onto the restore bus, and restore valid is high for exactly that one cycle.
- R10: An entry pulse while already in debug is ignored: the saved latch and both addresses keep their values.
- R11: A program-data write outside debug mode leaves the saved latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgEnter | input | 1 | Debug entry pulse |
| dbgExit | input | 1 | Debug exit pulse |
| goCmd | input | 1 | GO command pulse (re-arms first-write copy) |
| instLatch | input | 24 | Live instruction latch |
| fetchAddr | input | 16 | Live fetch-stage program address |
| decodeAddr | input | 16 | Live decode-stage program address |
| coreWrEn | input | 1 | Core I/O write strobe |
| coreWrAddr | input | 16 | Core I/O write address |
| coreWrData | input | 24 | Core I/O write data |
| pdbWrEn | input | 1 | Host program-data register write strobe |
| pdbWrData | input | 24 | Host program-data register write data |
| readCmd | input | 1 | Serial read command pulse |
| readSel | input | 2 | Register select for the read |
| dbgClk | input | 1 | Serial debug clock |
| dataOut | output | 1 | Serial data out |
| inDebug | output | 1 | Debug mode flag |
| restoreData | output | 24 | Saved latch presented on exit |
| restoreValid | output | 1 | One-cycle restore strobe |

## Verification
The saved latch is driven by a first capture, then by two program-data writes in a row, then by a GO followed by two more writes. This separates a missing first-write copy from a guard that never closes or never re-arms. Repeated entry pulses during a session, and writes made outside debug, show whether captures leak in when they should not. The global-data register gets a write to a neighbouring address and then one to 0xFFFC, so a loose address decode shows up. Each of the four select codes is read out serially with distinct bit patterns, and the read continues past the last bit, which exposes bit-order, select-mapping and fill errors.

// File: rtl/dbg_pipe_pkg.sv
package dbg_pipe_pkg;

  typedef enum logic [1:0] {
    SEL_SNAP   = 2'd0,
    SEL_GDB    = 2'd1,
    SEL_FETCH  = 2'd2,
    SEL_DECODE = 2'd3
  } readSel_e;

  typedef struct packed {
    logic capture;   // freeze latch and stage addresses
    logic loadSnap;  // copy program-data write into saved latch
    logic loadGdb;   // core write to the global-data register
    logic loadShift; // parallel load of the serial shifter
    logic shiftOne;  // advance the shifter by one bit
    logic restore;   // drive restore bus
  } ctlStrobes_t;

endpackage

// File: rtl/dbg_pipe_ctl.sv
module dbg_pipe_ctl
  import dbg_pipe_pkg::*;
#(
  parameter int IO_ADDR_W = 16,
  parameter logic [IO_ADDR_W-1:0] GDB_ADDR = 16'hFFFC,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dbgEnter,
  input  logic                 dbgExit,
  input  logic                 goCmd,
  input  logic                 coreWrEn,
  input  logic [IO_ADDR_W-1:0] coreWrAddr,
  input  logic                 pdbWrEn,
  input  logic                 readCmd,
  input  logic                 dbgClk,
  output logic                 inDebug,
  output logic                 firstPending,
  output ctlStrobes_t          strobes
);

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0] clkSync;
  logic                 dbgRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkSync <= '0;
    else       clkSync <= {clkSync[SYNC_STAGES-1:0], dbgClk};
  end

  assign dbgRise = clkSync[SYNC_TOP] & ~clkSync[SYNC_STAGES];

  always_comb begin
    strobes.capture   = dbgEnter & ~inDebug;
    strobes.restore   = dbgExit & inDebug;
    strobes.loadSnap  = pdbWrEn & inDebug & firstPending;
    strobes.loadGdb   = coreWrEn & (coreWrAddr == GDB_ADDR);
    strobes.loadShift = readCmd;
    strobes.shiftOne  = dbgRise & ~readCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inDebug      <= 1'b0;
      firstPending <= 1'b0;
    end else begin
      if (strobes.capture) begin
        inDebug      <= 1'b1;
        firstPending <= 1'b1;
      end else if (strobes.restore) begin
        inDebug      <= 1'b0;
        firstPending <= 1'b0;
      end else if (inDebug && goCmd) begin
        firstPending <= 1'b1;
      end else if (strobes.loadSnap) begin
        firstPending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dbg_pipe_dp.sv
module dbg_pipe_dp
  import dbg_pipe_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] instLatch,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] decodeAddr,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic [DATA_W-1:0] pdbWrData,
  input  logic [1:0]        readSel,
  output logic [DATA_W-1:0] snapReg,
  output logic [DATA_W-1:0] gdbReg,
  output logic [ADDR_W-1:0] fetchReg,
  output logic [ADDR_W-1:0] decodeReg,
  output logic              dataOut,
  output logic [DATA_W-1:0] restoreData,
  output logic              restoreValid
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] fetchWide, decodeWide, shiftSrc, shiftReg;

  generate
    if (PAD_W > 0) begin : g_pad
      assign fetchWide  = {{PAD_W{1'b0}}, fetchReg};
      assign decodeWide = {{PAD_W{1'b0}}, decodeReg};
    end else begin : g_trunc
      assign fetchWide  = fetchReg[DATA_W-1:0];
      assign decodeWide = decodeReg[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (readSel_e'(readSel))
      SEL_SNAP:   shiftSrc = snapReg;
      SEL_GDB:    shiftSrc = gdbReg;
      SEL_FETCH:  shiftSrc = fetchWide;
      default:    shiftSrc = decodeWide;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapReg   <= '0;
      fetchReg  <= '0;
      decodeReg <= '0;
    end else if (strobes.capture) begin
      snapReg   <= instLatch;
      fetchReg  <= fetchAddr;
      decodeReg <= decodeAddr;
    end else if (strobes.loadSnap) begin
      snapReg   <= pdbWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gdbReg <= '0;
    else if (strobes.loadGdb) gdbReg <= coreWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  shiftReg <= '0;
    else if (strobes.loadShift) shiftReg <= shiftSrc;
    else if (strobes.shiftOne)  shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
  end

  assign dataOut = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restoreData  <= '0;
      restoreValid <= 1'b0;
    end else begin
      restoreValid <= strobes.restore;
      if (strobes.restore) restoreData <= snapReg;
    end
  end

endmodule

// File: rtl/dbg_pipe_capture.sv
module dbg_pipe_capture
  import dbg_pipe_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16,
  parameter int IO_ADDR_W = 16,
  parameter logic [IO_ADDR_W-1:0] GDB_ADDR = 16'hFFFC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dbgEnter,
  input  logic                 dbgExit,
  input  logic                 goCmd,
  input  logic [DATA_W-1:0]    instLatch,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic [ADDR_W-1:0]    decodeAddr,
  input  logic                 coreWrEn,
  input  logic [IO_ADDR_W-1:0] coreWrAddr,
  input  logic [DATA_W-1:0]    coreWrData,
  input  logic                 pdbWrEn,
  input  logic [DATA_W-1:0]    pdbWrData,
  input  logic                 readCmd,
  input  logic [1:0]           readSel,
  input  logic                 dbgClk,
  output logic                 dataOut,
  output logic                 inDebug,
  output logic [DATA_W-1:0]    restoreData,
  output logic                 restoreValid
);

  ctlStrobes_t       strobes;
  logic              firstPending;
  logic [DATA_W-1:0] snapReg, gdbReg;
  logic [ADDR_W-1:0] fetchReg, decodeReg;

  dbg_pipe_ctl #(
    .IO_ADDR_W(IO_ADDR_W),
    .GDB_ADDR (GDB_ADDR),
    .SYNC_STAGES(2)
  ) u_ctl (
    .clk, .rstN, .dbgEnter, .dbgExit, .goCmd, .coreWrEn, .coreWrAddr,
    .pdbWrEn, .readCmd, .dbgClk, .inDebug, .firstPending, .strobes
  );

  dbg_pipe_dp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk, .rstN, .strobes, .instLatch, .fetchAddr, .decodeAddr,
    .coreWrData, .pdbWrData, .readSel, .snapReg, .gdbReg, .fetchReg,
    .decodeReg, .dataOut, .restoreData, .restoreValid
  );

endmodule

// File: rtl/dbg_pipe_capture_chk.sv
module dbg_pipe_capture_chk #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16,
  parameter int IO_ADDR_W = 16,
  parameter logic [IO_ADDR_W-1:0] GDB_ADDR = 16'hFFFC
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dbgEnter,
  input logic                 inDebug,
  input logic                 firstPending,
  input logic [DATA_W-1:0]    instLatch,
  input logic                 coreWrEn,
  input logic [IO_ADDR_W-1:0] coreWrAddr,
  input logic [DATA_W-1:0]    coreWrData,
  input logic [DATA_W-1:0]    snapReg,
  input logic [DATA_W-1:0]    gdbReg,
  input logic [ADDR_W-1:0]    fetchReg,
  input logic [ADDR_W-1:0]    decodeReg,
  input logic                 restoreValid
);

  // R2
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEnter && !inDebug) |=> (inDebug && snapReg == $past(instLatch)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dbgEnter && !inDebug) |=> ($stable(fetchReg) && $stable(decodeReg)));

  // R5
  snap_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!firstPending && !(dbgEnter && !inDebug)) |=> $stable(snapReg));

  // R11
  pending_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inDebug |-> !firstPending);

  // R7
  gdb_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && coreWrAddr == GDB_ADDR) |=> (gdbReg == $past(coreWrData)));

  // R9
  restore_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |=> !restoreValid);

  // R9
  restore_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |-> !inDebug);

endmodule

bind dbg_pipe_capture dbg_pipe_capture_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .GDB_ADDR(GDB_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .dbgEnter(dbgEnter), .inDebug(inDebug),
  .firstPending(firstPending), .instLatch(instLatch), .coreWrEn(coreWrEn),
  .coreWrAddr(coreWrAddr), .coreWrData(coreWrData), .snapReg(snapReg),
  .gdbReg(gdbReg), .fetchReg(fetchReg), .decodeReg(decodeReg),
  .restoreValid(restoreValid)
);

// File: tb/dbg_pipe_capture_test.sv
`timescale 1ns/1ps
module dbg_pipe_capture_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbgEnter = 0, dbgExit = 0, goCmd = 0;
  logic [23:0] instLatch = '0;
  logic [15:0] fetchAddr = '0, decodeAddr = '0;
  logic        coreWrEn = 0;
  logic [15:0] coreWrAddr = '0;
  logic [23:0] coreWrData = '0;
  logic        pdbWrEn = 0;
  logic [23:0] pdbWrData = '0;
  logic        readCmd = 0;
  logic [1:0]  readSel = '0;
  logic        dbgClk = 0;
  logic        dataOut, inDebug, restoreValid;
  logic [23:0] restoreData;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dbg_pipe_capture uut (.*);

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; cyc(); sig = 1'b0;
  endtask

  task automatic dbgEdge();
    dbgClk = 1'b1; cyc(3);
    dbgClk = 1'b0; cyc(3);
  endtask

  // serial read of 24 bits plus one extra edge for the fill bit
  task automatic readReg(logic [1:0] sel, output logic [23:0] val, output logic fill);
    readSel = sel; readCmd = 1'b1; cyc(); readCmd = 1'b0;
    for (int i = 0; i < 24; i++) begin
      val[i] = dataOut;
      if (i < 23) dbgEdge();
    end
    dbgEdge();
    fill = dataOut;
  endtask

  task automatic expectReg(string req, logic [1:0] sel, logic [23:0] exp);
    logic [23:0] v; logic f;
    readReg(sel, v, f);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R1 inDebug", {23'd0, inDebug}, 24'd0);
    check("R1 restoreValid", {23'd0, restoreValid}, 24'd0);
    check("R1 restoreData", restoreData, 24'd0);
    check("R1 dataOut", {23'd0, dataOut}, 24'd0);
    expectReg("R1 snap", 2'd0, 24'd0);
    expectReg("R1 gdb", 2'd1, 24'd0);
  endtask

  task automatic t_capture();
    instLatch = 24'hA5C33C; fetchAddr = 16'h1234; decodeAddr = 16'h1233;
    pulse(dbgEnter);
    check("R2 inDebug", {23'd0, inDebug}, 24'd1);
    instLatch = 24'h000000; fetchAddr = 16'hFFFF; decodeAddr = 16'h8001;
    cyc(2);
    expectReg("R2 snap", 2'd0, 24'hA5C33C);
    expectReg("R3 fetch", 2'd2, 24'h001234);
    expectReg("R3 decode", 2'd3, 24'h001233);
  endtask

  task automatic t_reenter();
    instLatch = 24'h5A5A5A; fetchAddr = 16'h4444;
    pulse(dbgEnter);
    cyc();
    expectReg("R10 snap", 2'd0, 24'hA5C33C);
    expectReg("R10 fetch", 2'd2, 24'h001234);
  endtask

  task automatic t_first_write();
    pdbWrData = 24'h111111; pulse(pdbWrEn);
    expectReg("R4 first write", 2'd0, 24'h111111);
    pdbWrData = 24'h222222; pulse(pdbWrEn);
    expectReg("R5 second write", 2'd0, 24'h111111);
  endtask

  task automatic t_gdb();
    coreWrAddr = 16'hFFFB; coreWrData = 24'h777777; pulse(coreWrEn);
    expectReg("R7 other addr", 2'd1, 24'h000000);
    coreWrAddr = 16'hFFFC; coreWrData = 24'hC0FFEE; pulse(coreWrEn);
    expectReg("R7 gdb addr", 2'd1, 24'hC0FFEE);
  endtask

  task automatic t_go();
    pulse(goCmd);
    pdbWrData = 24'h333333; pulse(pdbWrEn);
    expectReg("R6 after go", 2'd0, 24'h333333);
    pdbWrData = 24'h444444; pulse(pdbWrEn);
    expectReg("R6 second after go", 2'd0, 24'h333333);
  endtask

  task automatic t_exit();
    dbgExit = 1'b1; cyc(); dbgExit = 1'b0;
    check("R9 valid", {23'd0, restoreValid}, 24'd1);
    check("R9 data", restoreData, 24'h333333);
    check("R9 inDebug", {23'd0, inDebug}, 24'd0);
    cyc();
    check("R9 one cycle", {23'd0, restoreValid}, 24'd0);
  endtask

  task automatic t_outside();
    pdbWrData = 24'h555555; pulse(pdbWrEn);
    expectReg("R11 outside write", 2'd0, 24'h333333);
  endtask

  task automatic t_serial();
    logic [23:0] v; logic f;
    instLatch = 24'h800001; fetchAddr = 16'hBEEF; decodeAddr = 16'h0001;
    pulse(dbgEnter);
    readReg(2'd0, v, f);
    check("R8 lsb first", v, 24'h800001);
    check("R8 zero fill", {23'd0, f}, 24'd0);
    readReg(2'd2, v, f);
    check("R8 fetch zero-ext", v, 24'h00BEEF);
    readReg(2'd3, v, f);
    check("R8 decode sel", v, 24'h000001);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc();
    t_reset();
    t_capture();
    t_reenter();
    t_first_write();
    t_gdb();
    t_go();
    t_exit();
    t_outside();
    t_serial();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule